// File: doc/BRIEF.md
# Split Descriptor Ring Controller

This block owns a table of 128 buffer descriptors shared by a transmit ring and a receive ring. Each descriptor is two 32-bit words. Word 0 holds the length in bits 31:16 and the flag bits in bits 15:0. Word 1 holds a buffer address, which this block never interprets.

A programmable split count divides the table. Indices below the split count form the transmit ring, and the split count through 127 form the receive ring. The block keeps one current pointer for each ring and decides when the transmit datapath may send the current descriptor and when a received frame can be stored. When a frame completes, the block rewrites the flags and length in word 0 and raises the interrupt-source bits. Frame data movement belongs to a separate datapath. That datapath reports completions through the `tx_done` and `rx_done` strobes.

Software reaches the control registers through a small host register port. It reaches every descriptor word through a separate descriptor port. A single level interrupt output leaves the block.

Top module: `bd_ring_ctrl`

## Requirements
- R1: After a synchronous reset:
  - the split count reads 0x40, the transmit pointer is 0 and the receive pointer is 0x40;
  - the mode, source and mask registers read 0, and `irq` is low;
  - every descriptor word reads 0.
- R2: A host write of 128 or more to the split count leaves it unchanged. A write of 0 to 127 is stored.
- R3: Host register and descriptor addressing:
  - `reg_addr` 0 is the mode register: bit 0 enables receive and bit 1 enables transmit.
  - `reg_addr` 1 is the split count, 2 is the interrupt source and 3 is the interrupt mask.
  - Descriptor word `w` of index `i` sits at `desc_addr` = 2*i + w.
- R4: `tx_req` is high exactly when all of the following hold for the descriptor at `tx_ptr`:
  - transmit is enabled;
  - the split count is nonzero;
  - the ready bit 15 is set;
  - the length field is greater than 4.
- R5: The transmit pointer advances on `tx_done` while `tx_req` is high:
  - If the wrap bit 13 is set, the pointer goes to 0.
  - Otherwise it increments, and goes back to 0 when the incremented value reaches the split count.
  - `tx_done` while `tx_req` is low changes neither the pointer nor any descriptor.
- R6: On a transmit completion, word 0 has bits 15, 8, 7:4, 3, 2, 1 and 0 cleared and all other bits kept. If its IRQ bit 14 was set, source bit 0 is set.
- R7: `rx_ok` is high when receive is enabled and the empty bit 15 of the descriptor at `rx_ptr` is set. An `rx_done` with receive enabled and that bit clear sets source bit 4 and changes no descriptor and no pointer.
- R8: After an accepted receive, the receive pointer loads the split count if the wrap bit 13 is set or the pointer is 127. Otherwise it increments.
- R9: An accepted receive writes word 0 with `rx_len` in bits 31:16, bit 15 cleared and bits 14:0 kept. If its IRQ bit 14 was set, source bit 2 is set.
- R10: Mode-write enable edges:
  - A mode write that turns receive enable from 0 to 1 loads the receive pointer with the split count.
  - A mode write that turns transmit enable from 0 to 1 loads the transmit pointer with 0.
  - A mode write that leaves an enable set moves neither pointer.
- R11: Writing 1s to the source register clears those bits. An event that sets a bit in the same cycle as a write clearing it leaves the bit set.
- R12: `irq` is high whenever the source and the mask share a set bit.
- R13: `rx_done` while receive is disabled changes no descriptor, pointer or source bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 32 | Host register write data |
| reg_rdata | output | 32 | Host register read data (combinational) |
| desc_wr | input | 1 | Descriptor word write strobe |
| desc_addr | input | 8 | Descriptor word address, 2*index + word |
| desc_wdata | input | 32 | Descriptor write data |
| desc_rdata | output | 32 | Descriptor read data (combinational) |
| tx_done | input | 1 | Transmit datapath finished the current descriptor |
| tx_req | output | 1 | Current transmit descriptor may be sent |
| tx_ptr | output | 7 | Current transmit descriptor index |
| rx_done | input | 1 | Receive datapath finished a frame |
| rx_len | input | 16 | Length of the finished frame |
| rx_ok | output | 1 | Current receive descriptor can take a frame |
| rx_ptr | output | 7 | Current receive descriptor index |
| irq | output | 1 | Level interrupt |

## Verification
A pointer that advances wrongly shows up within one cycle as a wrong `tx_ptr` or `rx_ptr`. By the next completion it also shows up as an update to the wrong descriptor word. A stale or mis-decoded flag in word 0 becomes visible only when the bench reads that descriptor back. If the interrupt source has wrong set or clear priority, `irq` holds the wrong level from the cycle after the collision until software clears the source. The bench therefore reads descriptors back after every completion and checks the pointers and `irq` each cycle that matters.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
    // Flag positions inside descriptor word 0
    localparam int FLG_OWN   = 15;   // ready (tx) / empty (rx)
    localparam int FLG_IRQ   = 14;
    localparam int FLG_WRAP  = 13;
    localparam int LEN_LSB   = 16;
    localparam logic [31:0] TX_RETIRE_CLR = 32'h0000_81FF;

    // Interrupt source bit positions
    localparam int SRC_W     = 5;
    localparam int SRC_TXB   = 0;
    localparam int SRC_RXB   = 2;
    localparam int SRC_BUSY  = 4;

    typedef enum logic [1:0] {
        RA_MODE  = 2'd0,
        RA_SPLIT = 2'd1,
        RA_SRC   = 2'd2,
        RA_MASK  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic tx_en;
        logic rx_en;
    } mode_t;

    function automatic logic [31:0] tx_retire(input logic [31:0] w0);
        return w0 & ~TX_RETIRE_CLR;
    endfunction

    function automatic logic [31:0] rx_retire(input logic [15:0] flags,
                                              input logic [15:0] len);
        logic [15:0] f;
        f = flags;
        f[FLG_OWN] = 1'b0;
        return {len, f};
    endfunction
endpackage

// File: rtl/bd_table.sv
module bd_table #(
    parameter int IDX_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [IDX_W:0]     host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic [IDX_W-1:0]   tx_idx,
    output logic [31:0]        tx_word0,
    input  logic               tx_we,
    input  logic [31:0]        tx_wdata,
    input  logic [IDX_W-1:0]   rx_idx,
    output logic [31:0]        rx_word0,
    input  logic               rx_we,
    input  logic [31:0]        rx_wdata
);
    localparam int WORDS = 2 << IDX_W;

    logic [31:0] mem [WORDS];

    assign host_rdata = mem[host_addr];
    assign tx_word0   = mem[{tx_idx, 1'b0}];
    assign rx_word0   = mem[{rx_idx, 1'b0}];

    // Completion updates are ordered after the host write so they win a collision
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            if (host_we) mem[host_addr] <= host_wdata;
            if (tx_we)   mem[{tx_idx, 1'b0}] <= tx_wdata;
            if (rx_we)   mem[{rx_idx, 1'b0}] <= rx_wdata;
        end
    end
endmodule

// File: rtl/bd_tx_ring.sv
module bd_tx_ring
    import bd_ring_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int MIN_LEN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_en,
    input  logic               restart,
    input  logic [IDX_W:0]     split,
    input  logic [31:0]        word0,
    input  logic               done,
    output logic [IDX_W-1:0]   ptr,
    output logic               req,
    output logic               upd_we,
    output logic [31:0]        upd_data,
    output logic               set_txb
);
    localparam logic [15:0] MIN_LEN_V = 16'(MIN_LEN);

    logic           fire;
    logic [IDX_W:0] inc;
    logic [IDX_W-1:0] nxt;

    assign req  = tx_en && (split != '0) && word0[FLG_OWN]
                  && (word0[31:LEN_LSB] > MIN_LEN_V);
    assign fire = done && req;
    assign inc  = {1'b0, ptr} + 1'b1;

    always_comb begin
        if (word0[FLG_WRAP] || (inc >= split)) nxt = '0;
        else                                   nxt = inc[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)          ptr <= '0;
        else if (restart) ptr <= '0;
        else if (fire)    ptr <= nxt;
    end

    assign upd_we   = fire;
    assign upd_data = tx_retire(word0);
    assign set_txb  = fire && word0[FLG_IRQ];

    a_r5_ptr_in_region: assert property (@(posedge clk) disable iff (rst)
        (fire && !restart) |=> ({1'b0, ptr} < $past(split)));
    a_r5_idle_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !req && !restart) |=> $stable(ptr));
endmodule

// File: rtl/bd_rx_ring.sv
module bd_rx_ring
    import bd_ring_pkg::*;
#(
    parameter int IDX_W     = 7,
    parameter int SPLIT_RST = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_en,
    input  logic               restart,
    input  logic [IDX_W:0]     split,
    input  logic [15:0]        flags,
    input  logic               done,
    input  logic [15:0]        len,
    output logic [IDX_W-1:0]   ptr,
    output logic               ok,
    output logic               upd_we,
    output logic [31:0]        upd_data,
    output logic               set_rxb,
    output logic               set_busy
);
    localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(SPLIT_RST);

    logic accept;
    logic [IDX_W-1:0] nxt;

    assign ok       = rx_en && flags[FLG_OWN];
    assign accept   = done && ok;
    assign set_busy = done && rx_en && !flags[FLG_OWN];

    always_comb begin
        if (flags[FLG_WRAP] || (ptr == '1)) nxt = split[IDX_W-1:0];
        else                                nxt = ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          ptr <= PTR_RST;
        else if (restart) ptr <= split[IDX_W-1:0];
        else if (accept)  ptr <= nxt;
    end

    assign upd_we   = accept;
    assign upd_data = rx_retire(flags, len);
    assign set_rxb  = accept && flags[FLG_IRQ];

    a_r8_top_returns_to_split: assert property (@(posedge clk) disable iff (rst)
        (accept && !restart && (ptr == '1)) |=> (ptr == $past(split[IDX_W-1:0])));
    a_r13_disabled_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !rx_en && !restart) |=> $stable(ptr));
endmodule

// File: rtl/bd_irq_ctrl.sv
module bd_irq_ctrl
    import bd_ring_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_we,
    input  logic             mask_we,
    input  logic [SRC_W-1:0] wdata,
    input  logic [SRC_W-1:0] set_vec,
    output logic [SRC_W-1:0] src,
    output logic [SRC_W-1:0] mask,
    output logic             irq
);
    logic [SRC_W-1:0] clr_vec;

    assign clr_vec = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            src  <= '0;
            mask <= '0;
        end else begin
            src <= (src & ~clr_vec) | set_vec;
            if (mask_we) mask <= wdata;
        end
    end

    assign irq = |(src & mask);

    a_r11_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_we && (set_vec == '0)) |=> ((src & $past(wdata)) == '0));
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((src & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/bd_ring_ctrl.sv
module bd_ring_ctrl
    import bd_ring_pkg::*;
#(
    parameter int IDX_W     = 7,
    parameter int SPLIT_RST = 64,
    parameter int MIN_LEN   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               desc_wr,
    input  logic [IDX_W:0]     desc_addr,
    input  logic [31:0]        desc_wdata,
    output logic [31:0]        desc_rdata,
    input  logic               tx_done,
    output logic               tx_req,
    output logic [IDX_W-1:0]   tx_ptr,
    input  logic               rx_done,
    input  logic [15:0]        rx_len,
    output logic               rx_ok,
    output logic [IDX_W-1:0]   rx_ptr,
    output logic               irq
);
    localparam logic [31:0]    SPLIT_LIMIT = 32'(1 << IDX_W);
    localparam logic [IDX_W:0] SPLIT_INIT  = (IDX_W + 1)'(SPLIT_RST);

    mode_t            mode_q;
    logic [IDX_W:0]   split_q;
    logic             wr_mode, wr_split;
    logic             tx_restart, rx_restart;
    logic [31:0]      tx_w0, rx_w0, tx_upd, rx_upd;
    logic             tx_we, rx_we, set_txb, set_rxb, set_busy;
    logic [SRC_W-1:0] set_vec, src, mask;

    assign wr_mode    = reg_wr && (reg_sel_e'(reg_addr) == RA_MODE);
    assign wr_split   = reg_wr && (reg_sel_e'(reg_addr) == RA_SPLIT);
    assign tx_restart = wr_mode && reg_wdata[1] && !mode_q.tx_en;
    assign rx_restart = wr_mode && reg_wdata[0] && !mode_q.rx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            split_q <= SPLIT_INIT;
        end else begin
            if (wr_mode) mode_q <= mode_t'(reg_wdata[1:0]);
            if (wr_split && (reg_wdata < SPLIT_LIMIT)) split_q <= reg_wdata[IDX_W:0];
        end
    end

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            RA_MODE:  reg_rdata = {30'd0, mode_q};
            RA_SPLIT: reg_rdata = 32'(split_q);
            RA_SRC:   reg_rdata = 32'(src);
            default:  reg_rdata = 32'(mask);
        endcase
    end

    bd_table #(.IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst),
        .host_we(desc_wr), .host_addr(desc_addr),
        .host_wdata(desc_wdata), .host_rdata(desc_rdata),
        .tx_idx(tx_ptr), .tx_word0(tx_w0), .tx_we(tx_we), .tx_wdata(tx_upd),
        .rx_idx(rx_ptr), .rx_word0(rx_w0), .rx_we(rx_we), .rx_wdata(rx_upd)
    );

    bd_tx_ring #(.IDX_W(IDX_W), .MIN_LEN(MIN_LEN)) u_tx (
        .clk(clk), .rst(rst), .tx_en(mode_q.tx_en), .restart(tx_restart),
        .split(split_q), .word0(tx_w0), .done(tx_done),
        .ptr(tx_ptr), .req(tx_req), .upd_we(tx_we), .upd_data(tx_upd),
        .set_txb(set_txb)
    );

    bd_rx_ring #(.IDX_W(IDX_W), .SPLIT_RST(SPLIT_RST)) u_rx (
        .clk(clk), .rst(rst), .rx_en(mode_q.rx_en), .restart(rx_restart),
        .split(split_q), .flags(rx_w0[15:0]), .done(rx_done), .len(rx_len),
        .ptr(rx_ptr), .ok(rx_ok), .upd_we(rx_we), .upd_data(rx_upd),
        .set_rxb(set_rxb), .set_busy(set_busy)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[SRC_TXB]  = set_txb;
        set_vec[SRC_RXB]  = set_rxb;
        set_vec[SRC_BUSY] = set_busy;
    end

    bd_irq_ctrl u_irq (
        .clk(clk), .rst(rst),
        .clr_we(reg_wr && (reg_sel_e'(reg_addr) == RA_SRC)),
        .mask_we(reg_wr && (reg_sel_e'(reg_addr) == RA_MASK)),
        .wdata(reg_wdata[SRC_W-1:0]), .set_vec(set_vec),
        .src(src), .mask(mask), .irq(irq)
    );

    a_r2_oversize_split_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_split && (reg_wdata >= SPLIT_LIMIT)) |=> $stable(split_q));
    a_r7_busy_on_full: assert property (@(posedge clk) disable iff (rst)
        (rx_done && mode_q.rx_en && !rx_w0[FLG_OWN]) |=> src[SRC_BUSY]);
endmodule

// File: tb/test_bd_ring_ctrl.sv
module test_bd_ring_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        desc_wr = 1'b0;
    logic [7:0]  desc_addr = '0;
    logic [31:0] desc_wdata = '0;
    logic [31:0] desc_rdata;
    logic        tx_done = 1'b0;
    logic        tx_req;
    logic [6:0]  tx_ptr;
    logic        rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic        rx_ok;
    logic [6:0]  rx_ptr;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bd_ring_ctrl i_bd_ring_ctrl (.*);

    // {tx_en, split[7:0], word0[31:0], expected tx_req}
    localparam logic [41:0] VEC [6] = '{
        {1'b1, 8'd64, 32'h0005_8000, 1'b1},
        {1'b1, 8'd64, 32'h0004_8000, 1'b0},
        {1'b1, 8'd64, 32'h0005_0000, 1'b0},
        {1'b0, 8'd64, 32'h0005_8000, 1'b0},
        {1'b1, 8'd0,  32'h0005_8000, 1'b0},
        {1'b1, 8'd1,  32'hFFFF_8000, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr_desc(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        desc_wr = 1'b1; desc_addr = a; desc_wdata = d;
        @(negedge clk);
        desc_wr = 1'b0;
    endtask

    task automatic rd_desc(input logic [7:0] a, output logic [31:0] d);
        desc_addr = a;
        #1 d = desc_rdata;
    endtask

    task automatic pulse_tx;
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic pulse_rx(input logic [15:0] l);
        @(negedge clk); rx_done = 1'b1; rx_len = l;
        @(negedge clk); rx_done = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;

        // R1 / R3: reset state
        do_reset;
        chk("R1 tx_ptr", 32'(tx_ptr), 32'd0);
        chk("R1 rx_ptr", 32'(rx_ptr), 32'd64);
        chk("R1 irq", 32'(irq), 32'd0);
        rd_reg(2'd1, v); chk("R1 R3 split", v, 32'h40);
        rd_reg(2'd0, v); chk("R1 mode", v, 32'h0);
        rd_reg(2'd2, v); chk("R1 source", v, 32'h0);
        rd_reg(2'd3, v); chk("R1 mask", v, 32'h0);
        rd_desc(8'd0, v); chk("R1 desc0", v, 32'h0);
        rd_desc(8'd255, v); chk("R1 desc127 word1", v, 32'h0);

        // R4: start-condition table
        for (int k = 0; k < 6; k++) begin
            wr_reg(2'd0, {30'd0, VEC[k][41], 1'b0});
            wr_reg(2'd1, 32'(VEC[k][40:33]));
            wr_desc(8'd0, VEC[k][32:1]);
            chk($sformatf("R4 vector %0d tx_req", k), 32'(tx_req), 32'(VEC[k][0]));
        end

        // R2: split range
        do_reset;
        wr_reg(2'd1, 32'd128); rd_reg(2'd1, v); chk("R2 write 128 ignored", v, 32'h40);
        wr_reg(2'd1, 32'hFFFF_FF05); rd_reg(2'd1, v); chk("R2 large write ignored", v, 32'h40);
        wr_reg(2'd1, 32'd127); rd_reg(2'd1, v); chk("R2 write 127 stored", v, 32'd127);

        // Transmit ring: R5 R6 R10 R11 R12
        do_reset;
        wr_reg(2'd1, 32'd4);
        wr_desc(8'd0, 32'h0010_C9FF);
        wr_reg(2'd0, 32'd2);
        chk("R4 ready after enable", 32'(tx_req), 32'd1);
        pulse_tx;
        rd_desc(8'd0, v); chk("R6 retired flags", v, 32'h0010_4800);
        chk("R5 ptr increment", 32'(tx_ptr), 32'd1);
        rd_reg(2'd2, v); chk("R6 TXB set", v, 32'h1);
        chk("R12 masked off", 32'(irq), 32'd0);
        wr_reg(2'd3, 32'h1);
        chk("R12 irq on overlap", 32'(irq), 32'd1);
        wr_reg(2'd0, 32'd2);
        chk("R10 no reload without edge", 32'(tx_ptr), 32'd1);
        wr_reg(2'd2, 32'h1);
        rd_reg(2'd2, v); chk("R11 write-1 clears", v, 32'h0);
        chk("R12 irq drops", 32'(irq), 32'd0);
        wr_desc(8'd2, 32'h0010_8000);
        pulse_tx;
        chk("R5 ptr to 2", 32'(tx_ptr), 32'd2);
        rd_reg(2'd2, v); chk("R6 no TXB without IRQ bit", v, 32'h0);
        wr_desc(8'd4, 32'h0010_A000);
        pulse_tx;
        chk("R5 wrap bit to 0", 32'(tx_ptr), 32'd0);
        for (int i = 0; i < 4; i++) begin
            wr_desc(8'(2 * i), 32'h0010_8000);
            pulse_tx;
            chk($sformatf("R5 ring step %0d", i), 32'(tx_ptr), 32'((i + 1) % 4));
        end
        chk("R4 not ready after retire", 32'(tx_req), 32'd0);
        pulse_tx;
        chk("R5 idle done ptr", 32'(tx_ptr), 32'd0);
        rd_desc(8'd0, v); chk("R5 idle done desc", v, 32'h0010_0000);
        wr_desc(8'd0, 32'h0010_C000);
        @(negedge clk);
        tx_done = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h1;
        @(negedge clk);
        tx_done = 1'b0; reg_wr = 1'b0;
        rd_reg(2'd2, v); chk("R11 set wins over clear", v, 32'h1);
        chk("R12 irq with set bit", 32'(irq), 32'd1);
        chk("R5 ptr before restart", 32'(tx_ptr), 32'd1);
        wr_reg(2'd0, 32'd0);
        wr_reg(2'd0, 32'd2);
        chk("R10 tx enable edge", 32'(tx_ptr), 32'd0);

        // Receive ring: R7 R8 R9 R10 R12 R13
        do_reset;
        wr_reg(2'd1, 32'd126);
        wr_reg(2'd0, 32'd1);
        chk("R10 rx enable edge", 32'(rx_ptr), 32'd126);
        wr_desc(8'd252, 32'h0000_C000);
        wr_desc(8'd254, 32'h0000_8000);
        chk("R7 rx_ok", 32'(rx_ok), 32'd1);
        pulse_rx(16'h003C);
        rd_desc(8'd252, v); chk("R9 length and flags", v, 32'h003C_4000);
        chk("R8 increment", 32'(rx_ptr), 32'd127);
        rd_reg(2'd2, v); chk("R9 RXB set", v, 32'h4);
        pulse_rx(16'h0040);
        rd_desc(8'd254, v); chk("R9 no IRQ bit", v, 32'h0040_0000);
        chk("R8 top returns to split", 32'(rx_ptr), 32'd126);
        rd_reg(2'd2, v); chk("R9 no RXB without IRQ bit", v, 32'h4);
        chk("R7 not ok when full", 32'(rx_ok), 32'd0);
        pulse_rx(16'h0011);
        rd_reg(2'd2, v); chk("R7 BUSY set", v, 32'h14);
        chk("R7 ptr held", 32'(rx_ptr), 32'd126);
        rd_desc(8'd252, v); chk("R7 desc untouched", v, 32'h003C_4000);
        wr_reg(2'd3, 32'h10);
        chk("R12 busy irq", 32'(irq), 32'd1);
        wr_reg(2'd3, 32'h08);
        chk("R12 no overlap", 32'(irq), 32'd0);
        wr_reg(2'd1, 32'd120);
        wr_reg(2'd0, 32'd0);
        wr_reg(2'd0, 32'd1);
        chk("R10 reload new split", 32'(rx_ptr), 32'd120);
        wr_desc(8'd240, 32'h0000_A000);
        pulse_rx(16'h0022);
        rd_desc(8'd240, v); chk("R9 wrap desc", v, 32'h0022_2000);
        chk("R8 wrap bit to split", 32'(rx_ptr), 32'd120);
        wr_desc(8'd240, 32'h0000_8000);
        pulse_rx(16'h0005);
        chk("R8 plain increment", 32'(rx_ptr), 32'd121);
        wr_reg(2'd0, 32'd1);
        chk("R10 no rx reload without edge", 32'(rx_ptr), 32'd121);
        wr_reg(2'd0, 32'd0);
        wr_desc(8'd242, 32'h0000_C000);
        pulse_rx(16'h0033);
        rd_desc(8'd242, v); chk("R13 desc untouched", v, 32'h0000_C000);
        chk("R13 ptr held", 32'(rx_ptr), 32'd121);
        rd_reg(2'd2, v); chk("R13 source unchanged", v, 32'h14);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule